// File: doc/BRIEF.md
# Register-to-DRP Transaction Bridge

This block is a small memory-mapped register slave that gives a processor access to the dynamic reconfiguration port (DRP) of a clock-management tile. It decodes a plain 32-bit register bus (address, write strobe, read strobe, write data, registered read data). It also holds two configuration registers. The first drives a global enable and a tile enable. The second selects one of two clock sources.

A single write to the control register starts a complete DRP read or DRP write. The bridge drives a one-cycle DRP enable, with write-enable for writes. It holds a busy flag until the tile answers with ready. On a read it captures the returned word. Software polls the busy flag in the status register before it starts a transaction. After a read it polls again before it takes the data. A read-modify-write is therefore a read, a merge in software, and then a write.

Top module: `drp_bridge`

## Requirements
- R1: A write to offset 0x40 sets `sys_en_o` from data bit 0 and `tile_en_o` from data bit 1, both in the same access. A read of 0x40 returns them in bits 1:0 and zero elsewhere.
- R2: A write to offset 0x44 stores data bit 0 as the clock-source index on `clk_sel_o`. A read of 0x44 returns the last value written in bit 0 and zero elsewhere.
- R3: A write to offset 0x70 with bit 29 set while the bridge is idle starts a transaction. On the next cycle `drp_en_o` is high for exactly one cycle, `drp_addr_o` carries data bits 22:16, `drp_di_o` carries bits 15:0, and busy (bit 16 of offset 0x74) reads high.
- R4: Busy stays high until `drp_rdy_i` is sampled high and clears on the following cycle. Ready is only accepted while busy is high.
- R5: Bit 28 of the control word selects a read (1) or a write (0). `drp_we_o` is high only together with `drp_en_o`, and only for writes.
- R6: When a read transaction sees `drp_rdy_i` high, `drp_do_i` is captured and returned in bits 15:0 of offset 0x74.
- R7: A control write with bit 29 clear, or any control write while busy is high, is ignored. It produces no DRP enable and does not change the DRP address or data.
- R8: The read data in the status register changes only when a read transaction completes. Write transactions and ignored control writes leave it unchanged.
- R9: Reset (`rst_ni` low) clears busy, the read data, both enables, the clock select and the read-data port. Reads of offset 0x70 and of unmapped offsets return zero.
- R10: `reg_rdata_o` is updated on the clock edge that samples `reg_rd_i` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| sys_en_o | output | 1 | Global enable |
| tile_en_o | output | 1 | Clock-tile enable |
| clk_sel_o | output | 1 | Clock-source index |
| drp_en_o | output | 1 | DRP enable pulse |
| drp_we_o | output | 1 | DRP write enable |
| drp_addr_o | output | 7 | DRP register address |
| drp_di_o | output | 16 | DRP write data |
| drp_do_i | input | 16 | DRP read data |
| drp_rdy_i | input | 1 | DRP ready |

## Verification
The hardest case to reach from the ports is a control write that arrives while a transaction is still in flight. It must be dropped without disturbing the DRP address, the data or the held read data. The bench configures its DRP responder model for a long ready latency. It then issues a read and, one cycle later, a conflicting write. Afterwards it confirms that exactly one enable pulse occurred and that the target of the dropped write kept its contents. Randomised read-modify-write sequences with varying responder latency then cover the merge path and the stability of the captured data.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;
  localparam int REG_AW    = 8;
  localparam int REG_DW    = 32;
  localparam int DRP_AW    = 7;
  localparam int DRP_DW    = 16;

  localparam logic [REG_AW-1:0] OFS_RST    = 8'h40;
  localparam logic [REG_AW-1:0] OFS_CLKSEL = 8'h44;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 8'h70;
  localparam logic [REG_AW-1:0] OFS_STAT   = 8'h74;

  localparam int BIT_GO     = 29;
  localparam int BIT_RD     = 28;
  localparam int BIT_ADDR   = 16;
  localparam int BIT_BUSY   = 16;
  localparam int BIT_SYSEN  = 0;
  localparam int BIT_TILEEN = 1;
endpackage

// File: rtl/drp_cfg_regs.sv
module drp_cfg_regs
  import drp_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_rst_i,
  input  logic              wr_sel_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic              sys_en_o,
  output logic              tile_en_o,
  output logic              clk_sel_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_en_o  <= 1'b0;
      tile_en_o <= 1'b0;
      clk_sel_o <= 1'b0;
    end else begin
      if (wr_rst_i) begin
        sys_en_o  <= wdata_i[BIT_SYSEN];
        tile_en_o <= wdata_i[BIT_TILEEN];
      end
      if (wr_sel_i) clk_sel_o <= wdata_i[0];
    end
  end

  a_r1_both_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rst_i |=> (sys_en_o == $past(wdata_i[BIT_SYSEN])) && (tile_en_o == $past(wdata_i[BIT_TILEEN])));
  a_r2_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sel_i |=> $stable(clk_sel_o));

endmodule

// File: rtl/drp_txn_seq.sv
module drp_txn_seq
  import drp_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic              busy_o,
  output logic [DRP_DW-1:0] rd_data_o,
  output logic              drp_en_o,
  output logic              drp_we_o,
  output logic [DRP_AW-1:0] drp_addr_o,
  output logic [DRP_DW-1:0] drp_di_o,
  input  logic [DRP_DW-1:0] drp_do_i,
  input  logic              drp_rdy_i
);

  logic start;
  logic is_rd_q;
  logic done;

  assign start = ctrl_wr_i && wdata_i[BIT_GO] && !busy_o;
  assign done  = busy_o && drp_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      is_rd_q    <= 1'b0;
      drp_en_o   <= 1'b0;
      drp_we_o   <= 1'b0;
      drp_addr_o <= '0;
      drp_di_o   <= '0;
      rd_data_o  <= '0;
    end else begin
      drp_en_o <= start;
      drp_we_o <= start && !wdata_i[BIT_RD];
      if (start) begin
        busy_o     <= 1'b1;
        is_rd_q    <= wdata_i[BIT_RD];
        drp_addr_o <= wdata_i[BIT_ADDR +: DRP_AW];
        drp_di_o   <= wdata_i[DRP_DW-1:0];
      end else if (done) begin
        busy_o <= 1'b0;
        if (is_rd_q) rd_data_o <= drp_do_i;
      end
    end
  end

  a_r3_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && wdata_i[BIT_GO] && !busy_o) |=> (busy_o && drp_en_o));
  a_r3_en_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drp_en_o |=> !drp_en_o);
  a_r4_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !drp_rdy_i) |=> busy_o);
  a_r4_busy_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(drp_rdy_i));
  a_r5_we_with_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drp_we_o |-> drp_en_o);
  a_r7_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !drp_rdy_i) |=> ($stable(drp_addr_o) && $stable(drp_di_o) && !drp_en_o));
  a_r8_rdata_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && drp_rdy_i && is_rd_q) |=> $stable(rd_data_o));

endmodule

// File: rtl/drp_bridge.sv
module drp_bridge
  import drp_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              sys_en_o,
  output logic              tile_en_o,
  output logic              clk_sel_o,
  output logic              drp_en_o,
  output logic              drp_we_o,
  output logic [DRP_AW-1:0] drp_addr_o,
  output logic [DRP_DW-1:0] drp_di_o,
  input  logic [DRP_DW-1:0] drp_do_i,
  input  logic              drp_rdy_i
);

  logic              busy;
  logic [DRP_DW-1:0] rd_data;
  logic [REG_DW-1:0] rd_mux;

  drp_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_rst_i  (reg_wr_i && (reg_addr_i == OFS_RST)),
    .wr_sel_i  (reg_wr_i && (reg_addr_i == OFS_CLKSEL)),
    .wdata_i   (reg_wdata_i),
    .sys_en_o  (sys_en_o),
    .tile_en_o (tile_en_o),
    .clk_sel_o (clk_sel_o)
  );

  drp_txn_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (reg_wr_i && (reg_addr_i == OFS_CTRL)),
    .wdata_i    (reg_wdata_i),
    .busy_o     (busy),
    .rd_data_o  (rd_data),
    .drp_en_o   (drp_en_o),
    .drp_we_o   (drp_we_o),
    .drp_addr_o (drp_addr_o),
    .drp_di_o   (drp_di_o),
    .drp_do_i   (drp_do_i),
    .drp_rdy_i  (drp_rdy_i)
  );

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_i)
      OFS_RST: begin
        rd_mux[BIT_SYSEN]  = sys_en_o;
        rd_mux[BIT_TILEEN] = tile_en_o;
      end
      OFS_CLKSEL: rd_mux[0] = clk_sel_o;
      OFS_STAT: begin
        rd_mux[BIT_BUSY]     = busy;
        rd_mux[DRP_DW-1:0]   = rd_data;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o));
  a_r9_ctrl_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == OFS_CTRL) |=> (reg_rdata_o == '0));

endmodule

// File: tb/drp_bridge_test.sv
`timescale 1ns/1ps
module drp_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_en, tile_en, clk_sel;
  logic        drp_en, drp_we;
  logic [6:0]  drp_addr;
  logic [15:0] drp_di;
  logic [15:0] drp_do = '0;
  logic        drp_rdy = 1'b0;

  int n_chk = 0, n_bad = 0, en_cnt = 0, lat_cfg = 1;

  always #5 clk = ~clk;

  drp_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sys_en_o(sys_en), .tile_en_o(tile_en), .clk_sel_o(clk_sel),
    .drp_en_o(drp_en), .drp_we_o(drp_we), .drp_addr_o(drp_addr),
    .drp_di_o(drp_di), .drp_do_i(drp_do), .drp_rdy_i(drp_rdy)
  );

  function automatic logic [15:0] init_val(int a);
    return 16'((a * 32'h1357) ^ 32'hA5A5);
  endfunction

  // DRP responder model
  logic [15:0] mem [128];
  logic [15:0] exp_mem [128];
  logic        pend = 1'b0, pend_we = 1'b0;
  logic [6:0]  pa = '0;
  logic [15:0] pd = '0;
  int          cnt = 0;

  initial for (int i = 0; i < 128; i++) begin mem[i] = init_val(i); exp_mem[i] = init_val(i); end

  always @(posedge clk) begin
    drp_rdy <= 1'b0;
    if (drp_en) en_cnt++;
    if (pend) begin
      if (cnt == 0) begin
        drp_rdy <= 1'b1;
        drp_do  <= pend_we ? 16'h0 : mem[pa];
        if (pend_we) mem[pa] <= pd;
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (drp_en) begin
      pend <= 1'b1; pa <= drp_addr; pd <= drp_di; pend_we <= drp_we;
      cnt <= lat_cfg;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    for (int i = 0; i < 200; i++) begin
      rd(8'h74, st);
      if (!st[16]) return;
    end
    chk("R4 busy never cleared", st[16], 0);
  endtask

  function automatic logic [31:0] ctrl(bit go, bit is_rd, logic [6:0] a, logic [15:0] d);
    return (32'(go) << 29) | (32'(is_rd) << 28) | (32'(a) << 16) | 32'(d);
  endfunction

  task automatic drp_read(logic [6:0] a, output logic [15:0] v);
    logic [31:0] st;
    wait_idle(st);
    wr(8'h70, ctrl(1, 1, a, 16'h0));
    wait_idle(st);
    v = st[15:0];
  endtask

  task automatic drp_write(logic [6:0] a, logic [15:0] v);
    logic [31:0] st;
    wait_idle(st);
    wr(8'h70, ctrl(1, 0, a, v));
    exp_mem[a] = v;
    wait_idle(st);
  endtask

  initial begin
    logic [31:0] st, r;
    logic [15:0] v;
    int e0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 sys_en", sys_en, 0); chk("R9 tile_en", tile_en, 0);
    chk("R9 clk_sel", clk_sel, 0); chk("R9 rdata", reg_rdata, 0);
    chk("R9 drp_en", drp_en, 0);
    rst_n = 1'b1;
    rd(8'h74, st); chk("R9 status after reset", st, 0);

    // R1
    wr(8'h40, 32'h3); chk("R1 sys_en", sys_en, 1); chk("R1 tile_en", tile_en, 1);
    rd(8'h40, r); chk("R1 readback", r, 32'h3);
    wr(8'h40, 32'hFFFF_FFF1); chk("R1 tile off", tile_en, 0); chk("R1 sys on", sys_en, 1);
    rd(8'h40, r); chk("R1 readback2", r, 32'h1);

    // R2
    wr(8'h44, 32'h1); rd(8'h44, r); chk("R2 sel 1", r, 1); chk("R2 pin", clk_sel, 1);
    wr(8'h44, 32'hFFFF_FFFE); rd(8'h44, r); chk("R2 sel 0", r, 0);

    // R9 ctrl and unmapped read zero, R10 hold
    rd(8'h70, r); chk("R9 ctrl reads 0", r, 0);
    rd(8'h10, r); chk("R9 unmapped reads 0", r, 0);
    rd(8'h40, r);
    @(negedge clk); reg_addr = 8'h44; @(negedge clk);
    chk("R10 hold without strobe", reg_rdata, 32'h1);

    // R3/R5 write transaction
    lat_cfg = 3;
    wr(8'h70, ctrl(1, 0, 7'h2A, 16'hC0DE) | 32'h0F80_0000);
    exp_mem[7'h2A] = 16'hC0DE;
    chk("R3 en pulse", drp_en, 1); chk("R5 we on write", drp_we, 1);
    chk("R3 addr", drp_addr, 7'h2A); chk("R3 di", drp_di, 16'hC0DE);
    rd(8'h74, st);
    chk("R3 en one cycle", drp_en, 0); chk("R3 busy high", st[16], 1);
    wait_idle(st); chk("R4 busy cleared", st[16], 0);
    chk("R5 tile written", mem[7'h2A], 16'hC0DE);

    // R5/R6 read transaction
    wr(8'h70, ctrl(1, 1, 7'h2A, 16'h1111));
    chk("R5 we low on read", drp_we, 0); chk("R5 en on read", drp_en, 1);
    wait_idle(st); chk("R6 read data", st[15:0], 16'hC0DE);

    // R7 bit29 clear ignored
    e0 = en_cnt;
    wr(8'h70, ctrl(0, 0, 7'h05, 16'h9999));
    repeat (3) @(negedge clk);
    chk("R7 no enable when go clear", en_cnt, e0);
    rd(8'h74, st); chk("R7 not busy", st[16], 0); chk("R8 data kept", st[15:0], 16'hC0DE);

    // R8 write transaction keeps read data
    drp_write(7'h11, 16'h7777);
    rd(8'h74, st); chk("R8 data kept after write", st[15:0], 16'hC0DE);

    // R7 write while busy ignored
    lat_cfg = 8;
    e0 = en_cnt;
    wr(8'h70, ctrl(1, 1, 7'h05, 16'h0));
    wr(8'h70, ctrl(1, 0, 7'h09, 16'hBEEF));
    chk("R7 addr unchanged while busy", drp_addr, 7'h05);
    wait_idle(st);
    chk("R7 one enable only", en_cnt, e0 + 1);
    chk("R6 read addr5", st[15:0], exp_mem[5]);
    lat_cfg = 1;
    drp_read(7'h09, v); chk("R7 target untouched", v, exp_mem[9]);

    // randomised read-modify-write
    for (int k = 0; k < 40; k++) begin
      logic [6:0]  a;
      logic [15:0] m, d, nv;
      a = 7'($urandom % 128);
      m = 16'($urandom); d = 16'($urandom);
      lat_cfg = int'($urandom % 6);
      drp_read(a, v); chk("R6 random read", v, exp_mem[a]);
      nv = (v & ~m) | (d & m);
      drp_write(a, nv);
      rd(8'h74, st); chk("R8 rmw data held", st[15:0], v);
      drp_read(a, v); chk("R5 rmw result", v, nv);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule